// File: doc/BRIEF.md
# Dual-Core Mailbox FIFO Pair

This block links two processor cores through two word queues, one for each direction of traffic. Core 0 writes into the queue that core 1 drains, and core 1 writes into the queue that core 0 drains. Neither core can reach the read side of its own outgoing queue or the write side of its incoming one.

Each core has one small register port. A register select picks one of three targets: a push target for the outgoing queue, a pop target for the incoming queue, and a status word. The status word reports whether incoming data is waiting, whether the outgoing queue has room, and two sticky error flags. One error flag records a push that was dropped. The other records a pop that found nothing. A write of any value to the status target clears both error flags. Each core has one interrupt line, raised while data is waiting or either error flag is set.

Top module: `mbox_pair_top`

## Requirements
- R1: After a synchronous active-high reset both queues are empty, both error flags of both cores are clear, both interrupt lines are low and both read data outputs are zero.
- R2: Each queue holds DEPTH (default 8) words of WIDTH (default 32) bits and returns them in the order they were pushed.
- R3: A word pushed by core 0 can be popped only by core 1, and a word pushed by core 1 can be popped only by core 0. A core's own pushes never set its own data-valid flag.
- R4: A core's interrupt output is high exactly when its data-valid, write-overflow or read-underflow flag is set.
- R5: A push into a full queue, with no pop of that queue in the same cycle, is discarded and sets the pushing core's write-overflow flag. The flag stays set until cleared.
- R6: A core's ready flag is high exactly when its outgoing queue is not full.
- R7: A pop from an empty queue returns zero and sets the popping core's read-underflow flag. The flag stays set until cleared.
- R8: A write to a core's status target clears that core's two error flags. It leaves the contents of both queues unchanged.
- R9: A push and a pop on the same non-empty queue in the same cycle both take effect in that cycle. This also holds when the queue is full: the push is then accepted and no overflow is flagged.
- R10: The select encoding is 0 for status, 1 for push and 2 for pop. A read returns its data on rdata in the cycle after the access. The status word has data-valid in bit 0, ready in bit 1, write-overflow in bit 2 and read-underflow in bit 3, with all other bits zero. It reflects the state before the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| c0_sel | input | 2 | Core 0 register select |
| c0_wr | input | 1 | Core 0 write strobe |
| c0_rd | input | 1 | Core 0 read strobe |
| c0_wdata | input | WIDTH | Core 0 write data |
| c0_rdata | output | WIDTH | Core 0 read data, one cycle after the read |
| c0_irq | output | 1 | Core 0 interrupt |
| c1_sel | input | 2 | Core 1 register select |
| c1_wr | input | 1 | Core 1 write strobe |
| c1_rd | input | 1 | Core 1 read strobe |
| c1_wdata | input | WIDTH | Core 1 write data |
| c1_rdata | output | WIDTH | Core 1 read data, one cycle after the read |
| c1_irq | output | 1 | Core 1 interrupt |

## Verification
The bench builds the block with its default sizes, WIDTH 32 and DEPTH 8. The full boundary is therefore reached after eight pushes, which is short enough to fill a queue, overflow it and drain it several times. Repeated fill and drain cycles carry both pointers past their wrap point, so wrap bugs show up as wrong data order. The narrow queue also makes it cheap to hit the case of a simultaneous push and pop on a full queue.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  typedef enum logic [1:0] {
    SEL_STAT = 2'd0,
    SEL_PUSH = 2'd1,
    SEL_POP  = 2'd2
  } sel_e;

  localparam int unsigned ST_VALID = 0;
  localparam int unsigned ST_READY = 1;
  localparam int unsigned ST_WOF   = 2;
  localparam int unsigned ST_RUF   = 3;

  typedef enum logic [1:0] {
    RK_ZERO = 2'd0,
    RK_STAT = 2'd1,
    RK_DATA = 2'd2
  } rkind_e;
endpackage

// File: rtl/mbox_fifo.sv
module mbox_fifo #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] pop_data,
  output logic             full,
  output logic             nonempty,
  output logic             push_drop,
  output logic             pop_miss
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] CMAX = CW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;
  logic [CW-1:0]    count;
  logic [WIDTH-1:0] out_q;
  logic             pop_ok, push_ok;

  assign full      = (count == CMAX);
  assign nonempty  = (count != '0);
  assign pop_ok    = pop && nonempty;
  assign push_ok   = push && (!full || pop_ok);
  assign push_drop = push && !push_ok;
  assign pop_miss  = pop && !pop_ok;
  assign pop_data  = out_q;

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
    if (pop_ok)  out_q <= mem[rd_ptr];
    if (rst) out_q <= '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  p_count_bound_r2: assert property (@(posedge clk) disable iff (rst)
    count <= CMAX);
  p_drop_keeps_r5: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> $stable(count));
  p_same_cycle_r9: assert property (@(posedge clk) disable iff (rst)
    (push && pop && nonempty) |=> $stable(count));
endmodule

// File: rtl/mbox_core_port.sv
module mbox_core_port
  import mbox_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       sel,
  input  logic             wr,
  input  logic             rd,
  input  logic [WIDTH-1:0] wdata,
  input  logic             tx_full,
  input  logic             tx_drop,
  input  logic             rx_nonempty,
  input  logic             rx_miss,
  input  logic [WIDTH-1:0] rx_data,
  output logic             push,
  output logic [WIDTH-1:0] push_data,
  output logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             irq
);
  logic             wof_q, ruf_q;
  logic             clr;
  logic [3:0]       stat_now;
  logic [3:0]       stat_q;
  rkind_e           kind_q;

  assign push      = wr && (sel == SEL_PUSH);
  assign push_data = wdata;
  assign pop       = rd && (sel == SEL_POP);
  assign clr       = wr && (sel == SEL_STAT);

  always_comb begin
    stat_now = '0;
    stat_now[ST_VALID] = rx_nonempty;
    stat_now[ST_READY] = !tx_full;
    stat_now[ST_WOF]   = wof_q;
    stat_now[ST_RUF]   = ruf_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wof_q  <= 1'b0;
      ruf_q  <= 1'b0;
      stat_q <= '0;
      kind_q <= RK_ZERO;
    end else begin
      if (tx_drop)  wof_q <= 1'b1;
      else if (clr) wof_q <= 1'b0;
      if (rx_miss)  ruf_q <= 1'b1;
      else if (clr) ruf_q <= 1'b0;
      kind_q <= RK_ZERO;
      if (rd && sel == SEL_STAT) begin
        kind_q <= RK_STAT;
        stat_q <= stat_now;
      end else if (pop && !rx_miss) begin
        kind_q <= RK_DATA;
      end
    end
  end

  always_comb begin
    unique case (kind_q)
      RK_STAT: rdata = {{(WIDTH-4){1'b0}}, stat_q};
      RK_DATA: rdata = rx_data;
      default: rdata = '0;
    endcase
  end

  assign irq = rx_nonempty | wof_q | ruf_q;

  p_underflow_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (pop && rx_miss) |=> (rdata == '0) && ruf_q);
  p_wof_sticky_r5: assert property (@(posedge clk) disable iff (rst)
    (wof_q && !clr) |=> wof_q);
  p_clear_r8: assert property (@(posedge clk) disable iff (rst)
    clr |=> (!wof_q && !ruf_q));
  p_irq_err_r4: assert property (@(posedge clk) disable iff (rst)
    (tx_drop || rx_miss) |=> irq);
endmodule

// File: rtl/mbox_pair_top.sv
module mbox_pair_top #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DEPTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       c0_sel,
  input  logic             c0_wr,
  input  logic             c0_rd,
  input  logic [WIDTH-1:0] c0_wdata,
  output logic [WIDTH-1:0] c0_rdata,
  output logic             c0_irq,
  input  logic [1:0]       c1_sel,
  input  logic             c1_wr,
  input  logic             c1_rd,
  input  logic [WIDTH-1:0] c1_wdata,
  output logic [WIDTH-1:0] c1_rdata,
  output logic             c1_irq
);
  localparam int unsigned NCORE = 2;

  logic [1:0]       sel_a   [NCORE];
  logic             wr_a    [NCORE];
  logic             rd_a    [NCORE];
  logic [WIDTH-1:0] wdata_a [NCORE];
  logic [WIDTH-1:0] rdata_a [NCORE];
  logic             irq_a   [NCORE];

  // Queue q is written by core q and drained by the other core.
  logic             q_push  [NCORE];
  logic [WIDTH-1:0] q_pdata [NCORE];
  logic             q_pop   [NCORE];
  logic [WIDTH-1:0] q_odata [NCORE];
  logic             q_full  [NCORE];
  logic             q_ne    [NCORE];
  logic             q_drop  [NCORE];
  logic             q_miss  [NCORE];

  assign sel_a[0] = c0_sel;  assign sel_a[1] = c1_sel;
  assign wr_a[0]  = c0_wr;   assign wr_a[1]  = c1_wr;
  assign rd_a[0]  = c0_rd;   assign rd_a[1]  = c1_rd;
  assign wdata_a[0] = c0_wdata;
  assign wdata_a[1] = c1_wdata;
  assign c0_rdata = rdata_a[0];
  assign c1_rdata = rdata_a[1];
  assign c0_irq   = irq_a[0];
  assign c1_irq   = irq_a[1];

  for (genvar i = 0; i < NCORE; i++) begin : g_core
    localparam int unsigned PEER = NCORE - 1 - i;

    mbox_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_q (
      .clk       (clk),
      .rst       (rst),
      .push      (q_push[i]),
      .push_data (q_pdata[i]),
      .pop       (q_pop[i]),
      .pop_data  (q_odata[i]),
      .full      (q_full[i]),
      .nonempty  (q_ne[i]),
      .push_drop (q_drop[i]),
      .pop_miss  (q_miss[i])
    );

    mbox_core_port #(.WIDTH(WIDTH)) u_port (
      .clk         (clk),
      .rst         (rst),
      .sel         (sel_a[i]),
      .wr          (wr_a[i]),
      .rd          (rd_a[i]),
      .wdata       (wdata_a[i]),
      .tx_full     (q_full[i]),
      .tx_drop     (q_drop[i]),
      .rx_nonempty (q_ne[PEER]),
      .rx_miss     (q_miss[PEER]),
      .rx_data     (q_odata[PEER]),
      .push        (q_push[i]),
      .push_data   (q_pdata[i]),
      .pop         (q_pop[PEER]),
      .rdata       (rdata_a[i]),
      .irq         (irq_a[i])
    );
  end
endmodule

// File: tb/mbox_pair_top_tb.sv
module mbox_pair_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int D = 8;
  localparam logic [1:0] S_ST = 2'd0, S_PU = 2'd1, S_PO = 2'd2;
  localparam int NV = 12;
  // {core, sel, wr, rd, wdata, check, expected}
  localparam logic [69:0] VEC [NV] = '{
    {1'b0, S_PU, 1'b1, 1'b0, 32'h11, 1'b0, 32'h0},
    {1'b0, S_PU, 1'b1, 1'b0, 32'h22, 1'b0, 32'h0},
    {1'b1, S_ST, 1'b0, 1'b1, 32'h0,  1'b1, 32'h3},
    {1'b0, S_ST, 1'b0, 1'b1, 32'h0,  1'b1, 32'h2},
    {1'b1, S_PO, 1'b0, 1'b1, 32'h0,  1'b1, 32'h11},
    {1'b1, S_PU, 1'b1, 1'b0, 32'h33, 1'b0, 32'h0},
    {1'b0, S_PO, 1'b0, 1'b1, 32'h0,  1'b1, 32'h33},
    {1'b1, S_PO, 1'b0, 1'b1, 32'h0,  1'b1, 32'h22},
    {1'b1, S_PO, 1'b0, 1'b1, 32'h0,  1'b1, 32'h0},
    {1'b1, S_ST, 1'b0, 1'b1, 32'h0,  1'b1, 32'hA},
    {1'b1, S_ST, 1'b1, 1'b0, 32'h5,  1'b0, 32'h0},
    {1'b1, S_ST, 1'b0, 1'b1, 32'h0,  1'b1, 32'h2}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] c0_sel = '0, c1_sel = '0;
  logic c0_wr = 0, c0_rd = 0, c1_wr = 0, c1_rd = 0;
  logic [W-1:0] c0_wdata = '0, c1_wdata = '0;
  logic [W-1:0] c0_rdata, c1_rdata;
  logic c0_irq, c1_irq;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbox_pair_top #(.WIDTH(W), .DEPTH(D)) u_dut (
    .clk(clk), .rst(rst),
    .c0_sel(c0_sel), .c0_wr(c0_wr), .c0_rd(c0_rd), .c0_wdata(c0_wdata),
    .c0_rdata(c0_rdata), .c0_irq(c0_irq),
    .c1_sel(c1_sel), .c1_wr(c1_wr), .c1_rd(c1_rd), .c1_wdata(c1_wdata),
    .c1_rdata(c1_rdata), .c1_irq(c1_irq));

  task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge; drives one access for one cycle.
  task automatic op(int c, logic [1:0] s, logic w, logic r, logic [W-1:0] d);
    if (c == 0) begin c0_sel = s; c0_wr = w; c0_rd = r; c0_wdata = d; end
    else        begin c1_sel = s; c1_wr = w; c1_rd = r; c1_wdata = d; end
    @(negedge clk);
    c0_wr = 0; c0_rd = 0; c1_wr = 0; c1_rd = 0;
  endtask

  task automatic dual(logic [W-1:0] d);
    c0_sel = S_PU; c0_wr = 1; c0_wdata = d;
    c1_sel = S_PO; c1_rd = 1;
    @(negedge clk);
    c0_wr = 0; c1_rd = 0;
  endtask

  function automatic logic [W-1:0] rd_of(int c);
    return (c == 0) ? c0_rdata : c1_rdata;
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk("R1 c0_rdata", c0_rdata, 0);
    chk("R1 c1_rdata", c1_rdata, 0);
    chk("R1 irq", {30'b0, c1_irq, c0_irq}, 0);
    op(0, S_ST, 0, 1, 0);
    chk("R1 c0 status", c0_rdata, 32'h2);

    // Table walk: R3 cross wiring, R7 underflow, R8 clear, R10 layout
    for (int v = 0; v < NV; v++) begin
      logic [69:0] e;
      e = VEC[v];
      op(int'(e[69]), e[68:67], e[66], e[65], e[64:33]);
      if (e[32]) chk($sformatf("R3/R7/R10 vec %0d", v), rd_of(int'(e[69])), e[31:0]);
    end

    // R2, R5, R6 overflow and ordering
    for (int k = 0; k < D; k++) op(0, S_PU, 1, 0, 32'h100 + k);
    chk("R4 irq1 on valid", {31'b0, c1_irq}, 1);
    op(0, S_ST, 0, 1, 0);
    chk("R6 full not ready", c0_rdata, 32'h0);
    op(0, S_PU, 1, 0, 32'hDEAD);
    op(0, S_ST, 0, 1, 0);
    chk("R5 overflow flag", c0_rdata, 32'h4);
    chk("R4 irq0 on overflow", {31'b0, c0_irq}, 1);
    for (int k = 0; k < D; k++) begin
      op(1, S_PO, 0, 1, 0);
      chk("R2 order", c1_rdata, 32'h100 + k);
    end
    op(1, S_PO, 0, 1, 0);
    chk("R5 dropped word absent", c1_rdata, 32'h0);
    op(0, S_ST, 0, 1, 0);
    chk("R5 sticky, R6 ready back", c0_rdata, 32'h6);
    op(0, S_ST, 1, 0, 32'hFFFF_FFFF);
    op(0, S_ST, 0, 1, 0);
    chk("R8 clear", c0_rdata, 32'h2);
    chk("R4 irq0 low", {31'b0, c0_irq}, 0);

    // R8 clearing keeps contents
    op(0, S_PU, 1, 0, 32'h55);
    op(1, S_ST, 1, 0, 0);
    op(1, S_ST, 0, 1, 0);
    chk("R8 valid kept", c1_rdata, 32'h3);
    op(1, S_PO, 0, 1, 0);
    chk("R8 data kept", c1_rdata, 32'h55);

    // R9 same-cycle push and pop
    op(0, S_PU, 1, 0, 32'h61);
    dual(32'h62);
    chk("R9 pop during push", c1_rdata, 32'h61);
    op(1, S_ST, 0, 1, 0);
    chk("R9 one left", c1_rdata, 32'h3);
    op(1, S_PO, 0, 1, 0);
    chk("R9 second word", c1_rdata, 32'h62);
    op(1, S_ST, 0, 1, 0);
    chk("R9 empty after", c1_rdata, 32'h2);

    for (int k = 0; k < D; k++) op(0, S_PU, 1, 0, 32'h70 + k);
    dual(32'h99);
    chk("R9 full pop", c1_rdata, 32'h70);
    op(0, S_ST, 0, 1, 0);
    chk("R9 full no overflow", c0_rdata, 32'h0);
    for (int k = 1; k < D; k++) begin
      op(1, S_PO, 0, 1, 0);
      chk("R9 full drain order", c1_rdata, 32'h70 + k);
    end
    op(1, S_PO, 0, 1, 0);
    chk("R9 pushed at full", c1_rdata, 32'h99);
    chk("R4 irq1 idle", {31'b0, c1_irq}, 0);

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule